// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-clock synchronous memory that can alternate between reads and writes on every cycle with no idle cycles in between. Commands are sampled on the rising clock edge. A command carries the chip selects, the load/advance control, the read/write flag, the byte-lane enables and the address. Write data follows the command by a fixed two enabled edges. Read data appears after the same delay, so the data bus always trails the command bus by the same amount in both directions.

A loaded command can be extended into a four-beat burst. Each advance cycle steps the two low address bits in interleaved or linear order, and the burst keeps the read or write type it had when it was loaded. Accepted write data is held in a one-entry pending register and copied into the array when the next write arrives. Reads that hit the pending entry get the pending bytes merged over the array contents. A clock-enable stall freezes the whole block, a snooze input flushes the pipeline and ignores all commands, and an asynchronous output enable gates the read-data drivers.

Top module: `lw_sram`

## Requirements
- R1: A cycle with `adv` low loads a command only when `sel1_n` is low, `sel2` is high and `sel3_n` is low. Any other combination loads a deselect: nothing is read and the array does not change.
- R2: Read data for a command loaded at enabled edge k is on `q` after enabled edge k+2, with `q_drive` high (when `oe_n` is low) until the next enabled edge.
- R3: For a write loaded at enabled edge k, `din` is captured at enabled edge k+2. Only the lanes whose `lane_n` bit was low in the command cycle are written. Lane i is bits [9i+8:9i].
- R4: A write cycle with all eight `lane_n` bits high changes no array location. The burst still advances.
- R5: The read/write type of a burst is fixed when the command is loaded. On cycles with `adv` high, `wr_n` is ignored.
- R6: With `burst_lin_n` high, beat n of a burst (n = 0..3) addresses the start offset XOR n in the two low bits. The upper bits stay as loaded.
- R7: With `burst_lin_n` low, beat n addresses (start offset + n) mod 4. After four beats the sequence wraps to the start offset.
- R8: An advance cycle after a deselect, after a snooze or after reset is itself a deselect.
- R9: While `hold` is high, the clock edge is ignored: burst state, pipeline and `q`/`q_drive` keep their values.
- R10: An enabled edge with `snooze` high ignores every other input, flushes reads and writes still in flight so that no read data follows, keeps the array contents, and leaves the burst state deselected.
- R11: `q_drive` is low whenever `oe_n` is high (combinationally) and on any cycle that carries no read data.
- R12: A read loaded after a write to the same address returns the newer data byte by byte, including back-to-back write/read alternation with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | High: ignore this clock edge (stall) |
| snooze | input | 1 | High: power-down, inputs ignored, pipeline flushed |
| sel1_n | input | 1 | Active-low select, sampled on load cycles |
| sel2 | input | 1 | Active-high select, sampled on load cycles |
| sel3_n | input | 1 | Active-low select, sampled on load cycles |
| adv | input | 1 | Low: load a new command; high: advance the burst |
| wr_n | input | 1 | Low: write, high: read (load cycles only) |
| lane_n | input | 8 | Active-low byte-lane write enables, one per 9-bit lane |
| burst_lin_n | input | 1 | Static burst order: high interleaved, low linear |
| addr | input | AW (6) | Word address |
| din | input | 72 | Write data, two enabled edges after the command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| q | output | 72 | Read data register |
| q_drive | output | 1 | High when `q` would be driven onto the bus |

## Verification
A wrong burst offset or a lost read/write type shows up two enabled edges after the faulty command, as a read that returns another word's data or as a write that later reads back in the wrong place. Errors in the pending register or the lane merge only show up on a later read of the same address. That read may be the very next command, or it may come many cycles later, after the next write has committed the stale entry. A stall or snooze that disturbs the pipeline shows up on the following sampled cycle as a change on `q_drive` or `q`.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LANES = 8;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_READ  = 2'd1,
        BK_WRITE = 2'd2
    } burst_kind_e;

    // low two address bits for a given beat of a four-beat burst
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] step,
                                               input logic       linear);
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/lw_sram_burst.sv
module lw_sram_burst
    import lw_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          snooze,
    input  logic          adv,
    input  logic          sel,
    input  logic          wr_n,
    input  logic          linear,
    input  logic [AW-1:0] addr,
    output logic          op_vld,
    output logic          op_wr,
    output logic [AW-1:0] op_addr,
    output logic          live
);

    burst_kind_e   kind;
    logic [AW-3:0] upper;
    logic [1:0]    base;
    logic [1:0]    cnt;
    logic [1:0]    nxt_cnt;

    assign nxt_cnt = cnt + 2'd1;
    assign live    = (kind != BK_IDLE);

    always_comb begin
        op_vld  = 1'b0;
        op_wr   = 1'b0;
        op_addr = addr;
        if (!snooze) begin
            if (!adv) begin
                op_vld  = sel;
                op_wr   = !wr_n;
                op_addr = addr;
            end else begin
                op_vld  = (kind != BK_IDLE);
                op_wr   = (kind == BK_WRITE);
                op_addr = {upper, beat_offset(base, nxt_cnt, linear)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind  <= BK_IDLE;
            upper <= '0;
            base  <= '0;
            cnt   <= '0;
        end else if (en) begin
            if (snooze) begin
                kind <= BK_IDLE;
            end else if (!adv) begin
                kind  <= !sel ? BK_IDLE : (wr_n ? BK_READ : BK_WRITE);
                upper <= addr[AW-1:2];
                base  <= addr[1:0];
                cnt   <= '0;
            end else begin
                cnt <= nxt_cnt;
            end
        end
    end

endmodule

// File: rtl/lw_sram_store.sv
module lw_sram_store #(
    parameter int AW = 6,
    parameter int LW = 9,
    parameter int NL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NL-1:0]    wr_lanes,
    input  logic [NL*LW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [NL*LW-1:0] rd_data,
    output logic             pend_vld,
    output logic [AW-1:0]    pend_addr
);

    localparam int DEPTH = 1 << AW;

    logic [NL-1:0]    pend_lanes;
    logic [NL*LW-1:0] pend_data;
    logic             rd_hit;

    assign rd_hit = pend_vld && (pend_addr == rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld   <= 1'b0;
            pend_addr  <= '0;
            pend_lanes <= '0;
            pend_data  <= '0;
        end else if (wr_go) begin
            pend_vld   <= 1'b1;
            pend_addr  <= wr_addr;
            pend_lanes <= wr_lanes;
            pend_data  <= wr_data;
        end
    end

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [LW-1:0] bank [DEPTH];

        // older pending entry retires when a newer write takes its place
        always_ff @(posedge clk) begin
            if (wr_go && pend_vld && pend_lanes[l])
                bank[pend_addr] <= pend_data[l*LW +: LW];
        end

        assign rd_data[l*LW +: LW] = (rd_hit && pend_lanes[l])
                                     ? pend_data[l*LW +: LW]
                                     : bank[rd_addr];
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int LW = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic                snooze,
    input  logic                sel1_n,
    input  logic                sel2,
    input  logic                sel3_n,
    input  logic                adv,
    input  logic                wr_n,
    input  logic [LANES-1:0]    lane_n,
    input  logic                burst_lin_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] din,
    input  logic                oe_n,
    output logic [LANES*LW-1:0] q,
    output logic                q_drive
);

    localparam int DW = LANES * LW;

    logic          en;
    logic          sel;
    logic          op_vld, op_wr;
    logic [AW-1:0] op_addr;
    logic          brst_live;

    logic             s1_vld, s1_wr;
    logic [AW-1:0]    s1_addr;
    logic [LANES-1:0] s1_lanes;
    logic             s2_vld, s2_wr;
    logic [AW-1:0]    s2_addr;
    logic [LANES-1:0] s2_lanes;
    logic             q_valid;

    logic          s2_rd, s2_wr_abort, wr_go;
    logic [DW-1:0] rd_data;
    logic          pend_vld;
    logic [AW-1:0] pend_addr;

    assign en  = !hold;
    assign sel = !sel1_n && sel2 && !sel3_n;

    lw_sram_burst #(.AW(AW)) i_burst (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .snooze  (snooze),
        .adv     (adv),
        .sel     (sel),
        .wr_n    (wr_n),
        .linear  (!burst_lin_n),
        .addr    (addr),
        .op_vld  (op_vld),
        .op_wr   (op_wr),
        .op_addr (op_addr),
        .live    (brst_live)
    );

    assign s2_rd       = s2_vld && !s2_wr;
    assign s2_wr_abort = s2_vld && s2_wr && (s2_lanes == '0);
    assign wr_go       = en && !snooze && s2_vld && s2_wr && (s2_lanes != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s1_wr    <= 1'b0;
            s1_addr  <= '0;
            s1_lanes <= '0;
            s2_vld   <= 1'b0;
            s2_wr    <= 1'b0;
            s2_addr  <= '0;
            s2_lanes <= '0;
            q_valid  <= 1'b0;
            q        <= '0;
        end else if (en) begin
            if (snooze) begin
                s1_vld  <= 1'b0;
                s2_vld  <= 1'b0;
                q_valid <= 1'b0;
            end else begin
                s1_vld   <= op_vld;
                s1_wr    <= op_wr;
                s1_addr  <= op_addr;
                s1_lanes <= ~lane_n;
                s2_vld   <= s1_vld;
                s2_wr    <= s1_wr;
                s2_addr  <= s1_addr;
                s2_lanes <= s1_lanes;
                q_valid  <= s2_rd;
                if (s2_rd)
                    q <= rd_data;
            end
        end
    end

    lw_sram_store #(.AW(AW), .LW(LW), .NL(LANES)) i_store (
        .clk       (clk),
        .rst       (rst),
        .wr_go     (wr_go),
        .wr_addr   (s2_addr),
        .wr_lanes  (s2_lanes),
        .wr_data   (din),
        .rd_addr   (s2_addr),
        .rd_data   (rd_data),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr)
    );

    assign q_drive = q_valid && !oe_n;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int AW = 6,
    parameter int DW = 72
) (
    input logic          clk,
    input logic          rst,
    input logic          hold,
    input logic          snooze,
    input logic          adv,
    input logic          oe_n,
    input logic          q_drive,
    input logic          q_valid,
    input logic [DW-1:0] q,
    input logic          s1_vld,
    input logic          s2_rd,
    input logic          s2_wr_abort,
    input logic [AW-1:0] s2_addr,
    input logic          wr_go,
    input logic          pend_vld,
    input logic [AW-1:0] pend_addr,
    input logic          brst_live
);

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(q) && $stable(q_valid)));

    // R10
    snooze_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (snooze && !hold) |=> (!q_valid && !s1_vld && !brst_live));

    // R2
    read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (s2_rd && !hold && !snooze) |=> q_valid);

    // R8
    idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !brst_live && !hold) |=> !s1_vld);

    // R4
    abort_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (s2_wr_abort && !hold && !snooze) |=> ($stable(pend_vld) && $stable(pend_addr)));

    // R3
    write_take_chk: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> (pend_vld && pend_addr == $past(s2_addr)));

    // R11
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !q_drive);

endmodule

bind lw_sram lw_sram_chk #(.AW(AW), .DW(DW)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .hold        (hold),
    .snooze      (snooze),
    .adv         (adv),
    .oe_n        (oe_n),
    .q_drive     (q_drive),
    .q_valid     (q_valid),
    .q           (q),
    .s1_vld      (s1_vld),
    .s2_rd       (s2_rd),
    .s2_wr_abort (s2_wr_abort),
    .s2_addr     (s2_addr),
    .wr_go       (wr_go),
    .pend_vld    (pend_vld),
    .pend_addr   (pend_addr),
    .brst_live   (brst_live)
);

// File: tb/test_lw_sram.sv
module test_lw_sram;

    localparam int AW = 6;
    localparam int LW = 9;
    localparam int NL = 8;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold = 1'b0, snooze = 1'b0;
    logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic          adv = 1'b0, wr_n = 1'b1;
    logic [NL-1:0] lane_n = '1;
    logic          burst_lin_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] q;
    logic          q_drive;

    always #10 clk = ~clk;

    lw_sram #(.AW(AW), .LW(LW)) i_lw_sram (
        .clk(clk), .rst(rst), .hold(hold), .snooze(snooze),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .adv(adv), .wr_n(wr_n),
        .lane_n(lane_n), .burst_lin_n(burst_lin_n), .addr(addr), .din(din),
        .oe_n(oe_n), .q(q), .q_drive(q_drive)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    string cur_tag = "R2";

    logic [DW-1:0] ref_mem [1<<AW];
    int            bk = 0;             // 0 idle, 1 read, 2 write
    logic [AW-3:0] bup;
    logic [1:0]    bbase, bcnt;
    logic          b1_rd = 0, b1_wr = 0, b2_rd = 0, b2_wr = 0, last_rd = 0;
    logic [DW-1:0] b1_dat, b2_dat, b1_exp, b2_exp, last_exp;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rnd72();
        return {$urandom(), $urandom(), $urandom()};
    endfunction

    task automatic cycle(input bit h, input bit sz, input bit s1n, input bit s2, input bit s3n,
                         input bit ad, input bit wn, input logic [NL-1:0] ln,
                         input logic [AW-1:0] a, input bit oen);
        bit            selok, vld, wr;
        logic [AW-1:0] ea;
        logic [DW-1:0] d;
        @(negedge clk);
        oe_n = oen;
        #1;
        chk(q_drive == (last_rd && !oen), cur_tag, {71'd0, q_drive}, {71'd0, last_rd && !oen});
        if (last_rd && !oen)
            chk(q == last_exp, cur_tag, q, last_exp);
        hold = h; snooze = sz; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        adv = ad; wr_n = wn; lane_n = ln; addr = a;
        din = b2_wr ? b2_dat : rnd72();
        if (!h) begin
            last_rd  = b2_rd && !sz;
            last_exp = b2_exp;
            selok = !s1n && s2 && !s3n;
            vld = 0; wr = 0; ea = a;
            if (sz) begin
                bk = 0;
            end else if (!ad) begin
                vld = selok; wr = !wn; ea = a;
                bk = !selok ? 0 : (wn ? 1 : 2);
                bup = a[AW-1:2]; bbase = a[1:0]; bcnt = 0;
            end else begin
                bcnt = bcnt + 2'd1;
                vld = (bk != 0); wr = (bk == 2);
                ea = {bup, burst_lin_n ? (bbase ^ bcnt) : (bbase + bcnt)};
            end
            d = rnd72();
            if (vld && wr)
                for (int l = 0; l < NL; l++)
                    if (!ln[l]) ref_mem[ea][l*LW +: LW] = d[l*LW +: LW];
            b2_rd = sz ? 1'b0 : b1_rd; b2_wr = sz ? 1'b0 : b1_wr;
            b2_dat = b1_dat; b2_exp = b1_exp;
            b1_rd = vld && !wr; b1_wr = vld && wr;
            b1_dat = d; b1_exp = ref_mem[ea];
        end
    endtask

    task automatic ld(input bit w, input logic [AW-1:0] a, input logic [NL-1:0] ln);
        cycle(0, 0, 0, 1, 0, 0, !w, ln, a, 0);
    endtask
    task automatic nx(input logic [NL-1:0] ln);
        cycle(0, 0, 0, 1, 0, 1, $urandom() % 2, ln, AW'($urandom()), 0);
    endtask
    task automatic idle();
        cycle(0, 0, 1, 1, 0, 0, 1, '1, '0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 chk(q_drive == 1'b0, "R11", {71'd0, q_drive}, '0);
        // R8: advance right after reset is a deselect
        cur_tag = "R8";
        nx('0); nx('0); nx('0);
        // fill words 0..15 with full writes (R3)
        cur_tag = "R3";
        for (int i = 0; i < 16; i++) ld(1, AW'(i), '0);
        idle(); idle();
        for (int i = 0; i < 16; i++) ld(0, AW'(i), '1);
        // R3 partial lanes
        ld(1, 6'd5, 8'b1010_0110); idle(); idle(); ld(0, 6'd5, '1);
        // R4 abort inside a write burst, then read back
        cur_tag = "R4";
        ld(1, 6'd8, 8'hFF); nx('0); nx(8'hFF); nx('0); idle(); idle();
        ld(0, 6'd8, '1); nx('1); nx('1); nx('1);
        // R1 deselect variants do not write
        cur_tag = "R1";
        cycle(0, 0, 1, 1, 0, 0, 0, '0, 6'd3, 0);
        cycle(0, 0, 0, 0, 0, 0, 0, '0, 6'd3, 0);
        cycle(0, 0, 0, 1, 1, 0, 0, '0, 6'd3, 0);
        cycle(0, 0, 1, 1, 0, 0, 1, '1, 6'd3, 0);
        ld(0, 6'd3, '1);
        // R5 write burst with wr_n high on advances
        cur_tag = "R5";
        ld(1, 6'd12, '0);
        cycle(0, 0, 0, 1, 0, 1, 1, '0, 6'd0, 0);
        cycle(0, 0, 0, 1, 0, 1, 1, '0, 6'd0, 0);
        ld(0, 6'd12, '1); nx('1); nx('1); nx('1);
        // R6 interleaved burst from offset 1
        cur_tag = "R6";
        burst_lin_n = 1'b1;
        ld(0, 6'd9, '1); nx('1); nx('1); nx('1); idle();
        // R7 linear burst from offset 3, wrapping
        cur_tag = "R7";
        burst_lin_n = 1'b0;
        ld(0, 6'd7, '1); nx('1); nx('1); nx('1); nx('1); nx('1); idle();
        // R9 stall mid-burst
        cur_tag = "R9";
        ld(0, 6'd4, '1); nx('1);
        cycle(1, 0, 1, 0, 1, 0, 0, '0, 6'd1, 0);
        cycle(1, 0, 1, 0, 1, 0, 0, '0, 6'd1, 0);
        nx('1); nx('1); idle(); idle();
        // R10 snooze: drained pipe, write command ignored, read in flight dropped
        cur_tag = "R10";
        idle(); idle();
        ld(0, 6'd2, '1);
        cycle(0, 1, 0, 1, 0, 0, 0, '0, 6'd2, 0);
        nx('1); nx('1); idle(); idle();
        ld(0, 6'd2, '1); idle(); idle();
        // R11 output enable high on read data
        cur_tag = "R11";
        ld(0, 6'd1, '1); ld(0, 6'd2, '1);
        cycle(0, 0, 1, 1, 0, 0, 1, '1, 6'd0, 1);
        cycle(0, 0, 1, 1, 0, 0, 1, '1, 6'd0, 0);
        idle();
        // R12 back-to-back alternation on one address
        cur_tag = "R12";
        for (int i = 0; i < 6; i++) begin
            ld(1, 6'd6, 8'($urandom())); ld(0, 6'd6, '1);
        end
        idle(); idle();
        // random, both burst orders (R12 against reference)
        for (int m = 0; m < 2; m++) begin
            idle(); idle();
            burst_lin_n = (m == 0);
            for (int i = 0; i < 3000; i++) begin
                int  r = $urandom() % 100;
                bit  sok = ($urandom() % 100) < 85;
                logic [NL-1:0] ln;
                int  lr = $urandom() % 10;
                ln = (lr == 0) ? 8'hFF : (lr < 3 ? 8'($urandom()) : 8'h00);
                cycle(r < 10, 0, sok ? 1'b0 : 1'b1, 1'b1, 1'b0,
                      ($urandom() % 100) < 40, $urandom() % 2, ln,
                      AW'($urandom() % 16), ($urandom() % 10) == 0);
            end
            idle(); idle(); idle();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule